// File: doc/BRIEF.md
# Block Synchronization Tracker with Entry and Exit Protection

This block follows the block alignment of a broadcast data stream made of 26-bit blocks. An upstream syndrome and correction stage presents one beat per received block. Each beat carries a 3-bit offset-word code, a strobe that qualifies the beat, and a flag marking the block as uncorrectable. From these beats the tracker decides whether the stream is aligned. It gains alignment through an entry rule that looks back over recent blocks. It gives alignment up only after a configurable run of failing blocks, so that short bursts of bad blocks do not break it.

For every accepted beat the block returns one result beat with three flags. The first is the alignment state that applies to that block. The second reports whether the expected offset was really seen. The third marks a block that belongs to the acquisition window, so a downstream buffer can keep those blocks once alignment is declared. A synchronous resynchronize request drops alignment and empties the look-back history. The input side is valid/ready: `in_ready` is low only while the resynchronize request is high, and a beat offered then is discarded. The result side has no ready, because a broadcast stream cannot be paused; a consumer must take each `out_valid` beat in its cycle. The configuration inputs are plain levels.

Top module: `blk_sync_tracker`

## Requirements
- R1: While `sync_rst` is high, `in_ready` is low, the offered beat is discarded, `synced` is low from the next cycle, and blocks seen before the request never count toward a later acquisition.
- R2: `out_valid` is high for exactly the cycle after each accepted beat (`in_valid` and `in_ready` both high) and is low otherwise.
- R3: Code 000 is cycle position 0, code 001 is position 1, codes 010 and 011 are both position 2, and code 100 is position 3. Codes 110 and 111 are never detected.
- R4: Code 101 is recognised only while `cfg_e_en` is high. While aligned, it then counts as the expected offset at any position. It never takes part in acquisition. With `cfg_e_en` low it is treated as not detected.
- R5: With `cfg_acq_consec` high, alignment is declared on a block whose position is one more (mod 4) than that of the block directly before it, both detected. A gap block in between prevents this.
- R6: With `cfg_acq_consec` low, the R5 rule also applies. In addition, alignment is declared when a detected block's position is two more (mod 4) than that of the detected block two beats earlier, whatever the block between them was.
- R7: The declaring block reports `out_synced`=1, `out_found`=1 and `out_bwd`=1. The expected position of the next block is its position plus one.
- R8: While not aligned, and for blocks that do not declare alignment, `out_synced`=0. `out_found` and `out_bwd` both equal "a cycle offset (R3) was detected".
- R9: While aligned, the expected position advances by one on every block whatever arrived. `out_found` is 1 only when the block matched the expected offset. `out_bwd` is 0.
- R10: With `cfg_loss_on_err` low, a block fails when it does not match the expected offset. With `cfg_loss_on_err` high, a block fails when `in_uncorr` is high. Any passing block clears the run of failures.
- R11: `cfg_loss_sel` values 0 to 7 select a run length of 3, 4, 5, 6, 8, 10, 12 or 16 failing blocks. The block that completes the run reports `out_synced`=0, and `synced` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sync_rst | input | 1 | Resynchronize request, level, synchronous |
| in_valid | input | 1 | Block beat offered |
| in_ready | output | 1 | Beat accepted when high |
| in_code | input | 3 | Detected offset-word code |
| in_uncorr | input | 1 | Block could not be corrected |
| cfg_loss_sel | input | 3 | Run-length select for loss of alignment |
| cfg_loss_on_err | input | 1 | 0: failure is an out-of-order offset; 1: failure is an uncorrectable block |
| cfg_acq_consec | input | 1 | 0: two of three blocks; 1: two consecutive blocks |
| cfg_e_en | input | 1 | Recognise code 101 |
| synced | output | 1 | Current alignment state |
| out_valid | output | 1 | Result beat for the previous accepted block |
| out_synced | output | 1 | Alignment state that applies to that block |
| out_found | output | 1 | Expected offset was seen in that block |
| out_bwd | output | 1 | Block belongs to the acquisition window |

## Verification
Two things can happen in the same cycle: a resynchronize request, and a block beat that would complete an acquisition window. The bench sends one candidate block while not aligned. It then raises `sync_rst` while holding `in_valid` high with a block in order. It expects `in_ready` to be low, no result beat, and `synced` low. It then sends one further in-order block. That block must not declare alignment, which shows that neither the discarded beat nor the earlier candidate stayed in the history. The same overlap is also exercised while aligned, where the request must win over tracking.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  localparam int CODE_W   = 3;
  localparam int POS_W    = 2;
  localparam int LOSS_MAX = 16;
  localparam int LOSS_W   = $clog2(LOSS_MAX + 1);
  localparam int HIST_N   = 2;

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic det;   // in-cycle offset seen
    logic wild;  // extension offset, matches any slot while aligned
    pos_t pos;
  } ofs_info_t;

  function automatic logic [LOSS_W-1:0] loss_limit(input logic [2:0] sel);
    logic [LOSS_W-1:0] r;
    case (sel)
      3'd0: r = LOSS_W'(3);
      3'd1: r = LOSS_W'(4);
      3'd2: r = LOSS_W'(5);
      3'd3: r = LOSS_W'(6);
      3'd4: r = LOSS_W'(8);
      3'd5: r = LOSS_W'(10);
      3'd6: r = LOSS_W'(12);
      default: r = LOSS_W'(16);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ofs_classify.sv
module ofs_classify
  import bsync_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              e_en,
  output ofs_info_t         info
);
  always_comb begin
    info = '0;
    case (code)
      3'b000: begin info.det = 1'b1; info.pos = 2'd0; end
      3'b001: begin info.det = 1'b1; info.pos = 2'd1; end
      3'b010,
      3'b011: begin info.det = 1'b1; info.pos = 2'd2; end
      3'b100: begin info.det = 1'b1; info.pos = 2'd3; end
      3'b101: info.wild = e_en;
      default: info = '0;
    endcase
  end
endmodule

// File: rtl/acq_window.sv
module acq_window
  import bsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic consec_only,
  input  logic cur_det,
  input  pos_t cur_pos,
  output logic hit
);
  logic [HIST_N-1:0] h_v;
  pos_t              h_p [HIST_N];
  logic [HIST_N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < HIST_N; g++) begin : g_hist
      // entry g holds the block g+1 beats ago
      assign match[g] = h_v[g] && (cur_pos == pos_t'(h_p[g] + pos_t'(g + 1)));
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          h_v[g] <= 1'b0;
          h_p[g] <= '0;
        end else if (step) begin
          if (g == 0) begin
            h_v[g] <= cur_det;
            h_p[g] <= cur_pos;
          end else begin
            h_v[g] <= h_v[g-1];
            h_p[g] <= h_p[g-1];
          end
        end
      end
    end
  endgenerate

  assign hit = cur_det && (match[0] || (!consec_only && match[1]));
endmodule

// File: rtl/loss_counter.sv
module loss_counter
  import bsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              fail,
  input  logic [LOSS_W-1:0] limit,
  output logic              loss
);
  logic [LOSS_W-1:0] cnt;
  logic [LOSS_W:0]   nxt;

  assign nxt  = {1'b0, cnt} + (LOSS_W+1)'(1);
  assign loss = step && fail && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   cnt <= '0;
    else if (step)       cnt <= (fail && !loss) ? nxt[LOSS_W-1:0] : '0;
  end
endmodule

// File: rtl/blk_sync_tracker.sv
module blk_sync_tracker
  import bsync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_code,
  input  logic        in_uncorr,
  input  logic [2:0]  cfg_loss_sel,
  input  logic        cfg_loss_on_err,
  input  logic        cfg_acq_consec,
  input  logic        cfg_e_en,
  output logic        synced,
  output logic        out_valid,
  output logic        out_synced,
  output logic        out_found,
  output logic        out_bwd
);
  ofs_info_t info;
  pos_t      exp_q;
  logic      accept, acq_step, acq_hit, declare;
  logic      trk_step, in_order, fail, loss, hist_clr;

  assign in_ready = !sync_rst;
  assign accept   = in_valid && in_ready;
  assign acq_step = accept && !synced;
  assign trk_step = accept && synced;
  assign declare  = acq_step && acq_hit;
  assign hist_clr = sync_rst || declare;
  assign in_order = info.wild || (info.det && (info.pos == exp_q));
  assign fail     = cfg_loss_on_err ? in_uncorr : !in_order;

  ofs_classify u_cls (
    .code (in_code),
    .e_en (cfg_e_en),
    .info (info)
  );

  acq_window u_acq (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (hist_clr),
    .step        (acq_step),
    .consec_only (cfg_acq_consec),
    .cur_det     (info.det),
    .cur_pos     (info.pos),
    .hit         (acq_hit)
  );

  loss_counter u_loss (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hist_clr),
    .step  (trk_step),
    .fail  (fail),
    .limit (loss_limit(cfg_loss_sel)),
    .loss  (loss)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced     <= 1'b0;
      exp_q      <= '0;
      out_valid  <= 1'b0;
      out_synced <= 1'b0;
      out_found  <= 1'b0;
      out_bwd    <= 1'b0;
    end else begin
      out_valid <= accept;
      if (sync_rst) begin
        synced <= 1'b0;
      end else if (declare) begin
        synced <= 1'b1;
        exp_q  <= pos_t'(info.pos + 2'd1);
      end else if (trk_step) begin
        exp_q <= pos_t'(exp_q + 2'd1);
        if (loss) synced <= 1'b0;
      end
      if (trk_step) begin
        out_synced <= !loss;
        out_found  <= in_order;
        out_bwd    <= 1'b0;
      end else if (acq_step) begin
        out_synced <= declare;
        out_found  <= info.det;
        out_bwd    <= info.det;
      end
    end
  end
endmodule

// File: rtl/bsync_checker.sv
module bsync_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_code,
  input logic       cfg_loss_on_err,
  input logic       cfg_e_en,
  input logic       synced,
  input logic       out_valid,
  input logic       out_synced,
  input logic       out_found,
  input logic       out_bwd
);
  AST_RST_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst |-> !in_ready); // R1
  AST_RST_UNSYNCS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst |=> !synced); // R1
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R2
  AST_OUT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid); // R2
  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_code == 3'b101 && !cfg_e_en) |=> !out_found); // R4
  AST_DECLARE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> (out_valid && out_synced && out_found && out_bwd)); // R7
  AST_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_synced == synced)); // R8
  AST_BWD_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bwd) |-> !$past(synced)); // R8
  AST_HOLD_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_synced && !out_found) |-> $past(synced)); // R9
  AST_LOSS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(synced) && !$past(sync_rst) && !$past(cfg_loss_on_err))
      |-> (out_valid && !out_found && !out_synced)); // R11
endmodule

bind blk_sync_tracker bsync_checker u_chk (.*);

// File: tb/sim_blk_sync_tracker.sv
module sim_blk_sync_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_rst = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_code = 3'b000;
  logic in_uncorr = 1'b0;
  logic [2:0] cfg_loss_sel = 3'd2;
  logic cfg_loss_on_err = 1'b0;
  logic cfg_acq_consec = 1'b0;
  logic cfg_e_en = 1'b0;
  logic synced, out_valid, out_synced, out_found, out_bwd;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] CA = 3'b000, CB = 3'b001, CC = 3'b010, CCP = 3'b011,
                         CD = 3'b100, CE = 3'b101, CX6 = 3'b110, CX7 = 3'b111;

  always #5 clk = ~clk;

  blk_sync_tracker u0 (.*);

  task automatic chk(input logic act, input logic exp, input string rq, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", rq, what, act, exp, $time);
    end
  endtask

  // one block beat; result sampled one negedge later
  task automatic blk(input logic [2:0] c, input logic u, input logic es,
                     input logic ef, input logic eb, input string rq);
    @(negedge clk);
    in_valid = 1'b1; in_code = c; in_uncorr = u;
    @(negedge clk);
    in_valid = 1'b0; in_uncorr = 1'b0;
    chk(out_valid, 1'b1, "R2", "out_valid");
    chk(out_synced, es, rq, "out_synced");
    chk(out_found, ef, rq, "out_found");
    chk(out_bwd, eb, rq, "out_bwd");
    chk(synced, es, rq, "synced");
  endtask

  // resync request overlapping an offered in-order beat
  task automatic resync_overlap(input logic [2:0] c);
    @(negedge clk);
    sync_rst = 1'b1; in_valid = 1'b1; in_code = c;
    #1 chk(in_ready, 1'b0, "R1", "in_ready during request");
    @(negedge clk);
    chk(out_valid, 1'b0, "R2", "no beat while refused");
    chk(synced, 1'b0, "R1", "synced after request");
    sync_rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid, 1'b0, "R2", "idle after refused beat");
  endtask

  task automatic t_reset();
    chk(synced, 1'b0, "R1", "reset synced");
    chk(out_valid, 1'b0, "R2", "reset out_valid");
    chk(in_ready, 1'b1, "R1", "reset in_ready");
  endtask

  task automatic t_consec();
    cfg_acq_consec = 1'b1;
    blk(CA, 0, 0, 1, 1, "R8");
    blk(CB, 0, 1, 1, 1, "R5");
    blk(CCP, 0, 1, 1, 0, "R3");
    blk(CD, 0, 1, 1, 0, "R9");
    resync_overlap(CA);
    blk(CA, 0, 0, 1, 1, "R8");
    blk(CX6, 0, 0, 0, 0, "R3");
    blk(CC, 0, 0, 1, 1, "R5");
    blk(CD, 0, 1, 1, 1, "R7");
  endtask

  task automatic t_track();
    blk(CA, 0, 1, 1, 0, "R9");
    blk(CC, 0, 1, 0, 0, "R9");
    blk(CC, 0, 1, 1, 0, "R9");
  endtask

  task automatic t_ext_and_loss3();
    blk(CE, 0, 1, 0, 0, "R4");
    cfg_e_en = 1'b1;
    blk(CE, 0, 1, 1, 0, "R4");
    cfg_loss_sel = 3'd0;
    blk(CX6, 0, 1, 0, 0, "R10");
    blk(CX7, 0, 1, 0, 0, "R10");
    blk(CD, 0, 1, 1, 0, "R10");
    blk(CX6, 0, 1, 0, 0, "R11");
    blk(CX6, 0, 1, 0, 0, "R11");
    blk(CX6, 0, 0, 0, 0, "R11");
  endtask

  task automatic t_two_of_three();
    cfg_acq_consec = 1'b0;
    blk(CE, 0, 0, 0, 0, "R4");
    blk(CA, 0, 0, 1, 1, "R8");
    blk(CE, 0, 0, 0, 0, "R4");
    blk(CC, 0, 1, 1, 1, "R6");
  endtask

  task automatic t_loss16();
    cfg_loss_sel = 3'd7;
    for (int i = 0; i < 15; i++) blk(CX6, 0, 1, 0, 0, "R11");
    blk(CX6, 0, 0, 0, 0, "R11");
    blk(CD, 0, 0, 1, 1, "R8");
    blk(CX7, 0, 0, 0, 0, "R8");
    blk(CB, 0, 1, 1, 1, "R6");
  endtask

  task automatic t_err_crit();
    cfg_loss_on_err = 1'b1;
    cfg_loss_sel = 3'd1;
    blk(CX6, 0, 1, 0, 0, "R10");
    blk(CD, 1, 1, 1, 0, "R10");
    blk(CA, 1, 1, 1, 0, "R10");
    blk(CB, 1, 1, 1, 0, "R10");
    blk(CC, 0, 1, 1, 0, "R10");
    blk(CD, 1, 1, 1, 0, "R11");
    blk(CA, 1, 1, 1, 0, "R11");
    blk(CB, 1, 1, 1, 0, "R11");
    blk(CC, 1, 0, 1, 0, "R11");
  endtask

  task automatic t_resync_history();
    cfg_acq_consec = 1'b1;
    blk(CA, 0, 0, 1, 1, "R8");
    resync_overlap(CB);
    blk(CB, 0, 0, 1, 1, "R1");
    blk(CC, 0, 1, 1, 1, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_consec();
    t_track();
    t_ext_and_loss3();
    t_two_of_three();
    t_loss16();
    t_err_crit();
    t_resync_history();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule